// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit

This block is the bit-level engine of a two-wire serial bus port whose protocol is run by software. It holds an 8-bit shift register that puts its most significant bit on the data line while the clock line is low and takes a new bit into its least significant bit on each clock rising edge. A 4-bit counter advances on every clock-line edge, so sixteen edges make one byte. When the counter wraps, an overflow flag is raised and the finished byte is copied into a buffer register. Start and stop conditions on the bus raise their own status flags. After a start or an overflow, the block holds the clock line low until software clears the flag, which gives software time to act between bytes.

Software reaches four registers through a plain register port. Address 0 is the shift register (read/write). Address 1 is the buffer (read only). Address 2 is status: bit 7 is start, bit 6 is overflow, bit 5 is stop, bit 4 is collision and bits 3:0 are the counter. Address 3 is control: on write, bit 1 enables data-line driving and bit 0 is a clock-toggle strobe; on read, bit 1 is the drive enable and bit 0 is the clock output level. Both bus lines are open-drain. The block only pulls a line low or releases it, and it samples both lines through a two-flop synchronizer. There is no streaming data path: every transfer is a register access, so no valid/ready handshake and no back-pressure applies.

Top module: `twi_shift_unit`

## Requirements
- R1: After reset the shift register reads 0xFF, status reads 0x00, control reads 0x01, the buffer reads 0x00, and neither line is pulled low.
- R2: The data line falling while the clock line is high sets status bit 7 (start).
- R3: While the start flag is set, the next clock-line falling edge makes the block hold the clock line low. Clearing the flag releases the line.
- R4: The counter (status bits 3:0) advances on both clock-line edges. On the edge where it wraps from 15 to 0 it sets status bit 6 (overflow), and the clock line is then held low until that flag is cleared.
- R5: Every status write loads bits 3:0 into the counter. A load of binary 1110 overflows after exactly one rising edge and one falling edge, and not after the rising edge alone.
- R6: On overflow the buffer (address 1) takes the shift register's contents. Received bits enter most significant bit first.
- R7: The data line rising while the clock line is high sets status bit 5 (stop) and does not hold the clock line.
- R8: Writing 1 to status bits 7, 6 or 5 clears that flag. Writing 0 leaves it unchanged.
- R9: A control write with bit 0 set inverts the clock output level. Level 0 pulls the clock line low.
- R10: With control bit 1 set, the data line is pulled low exactly when the shift register's bit 7 is 0, and the register shifts left on each clock falling edge. With control bit 1 clear, the data line is released.
- R11: On each clock rising edge, status bit 4 (collision) is set to 1 if driving is enabled and the driven bit differs from the sampled data line, and to 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 shift, 1 buffer, 2 status, 3 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| scl_in | input | 1 | Sampled clock-line level |
| sda_in | input | 1 | Sampled data-line level |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The bench receives 0xA5 from a modelled external master. Its alternating bits show whether bits arrive in order and land in the right positions. It then transmits 0xC3 under its own clock toggling. The paired runs of equal bits in that byte separate a correct shift on the falling edge from a shift that is late or repeated, and the bench checks the data-line pin before every bit. A single-bit acknowledge run from a counter preload separates an overflow after the full bit period from one that comes early on the rising edge. A contended bit, where the block releases the data line and the external side pulls it low, must raise the collision flag, while the clean transfers must leave it clear.

// File: rtl/twi_shift_pkg.sv
package twi_shift_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_BUF  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam int CTRL_TOGGLE = 0;
  localparam int CTRL_DRIVE  = 1;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } pin_ev_t;

endpackage

// File: rtl/twi_pin_sync.sv
module twi_pin_sync
  import twi_shift_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pin_i,
  output pin_ev_t ev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  always_comb begin
    ev_o.level = chain_q[STAGES-1];
    ev_o.rise  = chain_q[STAGES-1] & ~prev_q;
    ev_o.fall  = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect
  import twi_shift_pkg::*;
(
  input  pin_ev_t scl_ev,
  input  pin_ev_t sda_ev,
  output logic    start_evt,
  output logic    stop_evt
);
  // Bus conditions: data moves while clock is high
  always_comb begin
    start_evt = sda_ev.fall & scl_ev.level;
    stop_evt  = sda_ev.rise & scl_ev.level;
  end
endmodule

// File: rtl/twi_edge_counter.sv
module twi_edge_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val;
    else if (edge_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = edge_i & ~load_i & (cnt_q == CNT_MAX);
endmodule

// File: rtl/twi_shifter.sv
module twi_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  output logic [DATA_W-1:0] shift_o,
  output logic [DATA_W-1:0] shift_next_o
);
  logic [DATA_W-1:0] shift_q;
  logic              cap_q;

  always_comb begin
    if (wr_i)        shift_next_o = wdata_i;
    else if (fall_i) shift_next_o = {shift_q[DATA_W-2:0], cap_q};
    else             shift_next_o = shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '1;
      cap_q   <= 1'b1;
    end else begin
      if (rise_i) cap_q <= sda_i;
      shift_q <= shift_next_o;
    end
  end

  assign shift_o = shift_q;
endmodule

// File: rtl/twi_shift_unit.sv
module twi_shift_unit
  import twi_shift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int CNT_W   = $clog2(2 * DATA_W);
  localparam int ST_START = DATA_W - 1;
  localparam int ST_OVF   = DATA_W - 2;
  localparam int ST_STOP  = DATA_W - 3;
  localparam int ST_COLL  = DATA_W - 4;
  localparam int NPINS    = 2;

  // pin index 0 = clock line, 1 = data line
  logic [NPINS-1:0] pins_in;
  pin_ev_t          pin_ev [NPINS];
  pin_ev_t          scl_ev, sda_ev;

  assign pins_in = {sda_in, scl_in};

  for (genvar p = 0; p < NPINS; p++) begin : g_sync
    twi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pins_in[p]),
      .ev_o  (pin_ev[p])
    );
  end

  assign scl_ev = pin_ev[0];
  assign sda_ev = pin_ev[1];

  logic data_wr, stat_wr, ctrl_wr;
  assign data_wr = reg_wr & (reg_addr == SEL_DATA);
  assign stat_wr = reg_wr & (reg_addr == SEL_STAT);
  assign ctrl_wr = reg_wr & (reg_addr == SEL_CTRL);

  logic start_evt, stop_evt;
  twi_cond_detect u_cond (
    .scl_ev    (scl_ev),
    .sda_ev    (sda_ev),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  twi_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_i   (scl_ev.rise | scl_ev.fall),
    .load_i   (stat_wr),
    .load_val (reg_wdata[CNT_W-1:0]),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  logic [DATA_W-1:0] shift_q, shift_d;
  twi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (data_wr),
    .wdata_i      (reg_wdata),
    .rise_i       (scl_ev.rise),
    .fall_i       (scl_ev.fall),
    .sda_i        (sda_ev.level),
    .shift_o      (shift_q),
    .shift_next_o (shift_d)
  );

  logic              start_q, ovf_q, stop_q, coll_q, hold_q;
  logic              scl_lvl_q, drive_q;
  logic [DATA_W-1:0] buf_q;
  logic              start_d, ovf_d, stop_d, hold_d;

  // flag set wins over a same-cycle write-one-to-clear
  always_comb begin
    start_d = start_evt | (start_q & ~(stat_wr & reg_wdata[ST_START]));
    ovf_d   = wrap      | (ovf_q   & ~(stat_wr & reg_wdata[ST_OVF]));
    stop_d  = stop_evt  | (stop_q  & ~(stat_wr & reg_wdata[ST_STOP]));
    hold_d  = (start_d | ovf_d) & (hold_q | scl_ev.fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      ovf_q     <= 1'b0;
      stop_q    <= 1'b0;
      hold_q    <= 1'b0;
      coll_q    <= 1'b0;
      scl_lvl_q <= 1'b1;
      drive_q   <= 1'b0;
      buf_q     <= '0;
    end else begin
      start_q <= start_d;
      ovf_q   <= ovf_d;
      stop_q  <= stop_d;
      hold_q  <= hold_d;
      if (scl_ev.rise) coll_q <= drive_q & (shift_q[DATA_W-1] != sda_ev.level);
      if (wrap) buf_q <= shift_d;
      if (ctrl_wr) begin
        drive_q <= reg_wdata[CTRL_DRIVE];
        if (reg_wdata[CTRL_TOGGLE]) scl_lvl_q <= ~scl_lvl_q;
      end
    end
  end

  assign scl_oe = ~scl_lvl_q | hold_q;
  assign sda_oe = drive_q & ~shift_q[DATA_W-1];

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      SEL_DATA: reg_rdata = shift_q;
      SEL_BUF:  reg_rdata = buf_q;
      SEL_STAT: begin
        reg_rdata[ST_START]  = start_q;
        reg_rdata[ST_OVF]    = ovf_q;
        reg_rdata[ST_STOP]   = stop_q;
        reg_rdata[ST_COLL]   = coll_q;
        reg_rdata[CNT_W-1:0] = cnt;
      end
      default: begin
        reg_rdata[CTRL_DRIVE]  = drive_q;
        reg_rdata[CTRL_TOGGLE] = scl_lvl_q;
      end
    endcase
  end
endmodule

// File: rtl/twi_shift_unit_chk.sv
module twi_shift_unit_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              scl_fall,
  input logic              scl_edge,
  input logic              stat_wr,
  input logic [CNT_W-1:0]  cnt,
  input logic              start_q,
  input logic              ovf_q,
  input logic              stop_q,
  input logic              drive_q,
  input logic              scl_lvl_q,
  input logic [DATA_W-1:0] shift_q,
  input logic [DATA_W-1:0] buf_q
);
  AST_START_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> start_q); // R2

  AST_HOLD_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && scl_fall && !stat_wr) |=> scl_oe); // R3

  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_edge && !stat_wr && cnt == '1) |=> (ovf_q && cnt == '0)); // R4

  AST_LOAD_COUNTER: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> cnt == $past(reg_wdata[CNT_W-1:0])); // R5

  AST_BUF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_edge && !stat_wr && cnt == '1) |=> buf_q == shift_q); // R6

  AST_STOP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> stop_q); // R7

  AST_W1C_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !reg_wdata[DATA_W-3] && stop_q) |=> stop_q); // R8

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3 && reg_wdata[0]) |=> scl_lvl_q != $past(scl_lvl_q)); // R9

  AST_SDA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_q |-> !sda_oe); // R10
endmodule

bind twi_shift_unit twi_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .scl_fall  (scl_ev.fall),
  .scl_edge  (scl_ev.rise | scl_ev.fall),
  .stat_wr   (stat_wr),
  .cnt       (cnt),
  .start_q   (start_q),
  .ovf_q     (ovf_q),
  .stop_q    (stop_q),
  .drive_q   (drive_q),
  .scl_lvl_q (scl_lvl_q),
  .shift_q   (shift_q),
  .buf_q     (buf_q)
);

// File: tb/twi_shift_unit_test.sv
module twi_shift_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe;
  logic       ext_scl_low = 1'b0;
  logic       ext_sda_low = 1'b0;
  logic       scl_in, sda_in;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q [$];
  logic [7:0] got_buf;
  event       buf_ready;

  always #4 clk = ~clk; // 125 MHz

  assign scl_in = ~(scl_oe | ext_scl_low);
  assign sda_in = ~(sda_oe | ext_sda_low);

  twi_shift_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // Driver: external master clocks one byte in, expected item to scoreboard
  task automatic ext_send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    for (int i = 7; i >= 0; i--) begin
      ext_sda_low = ~b[i];
      settle();
      ext_scl_low = 1'b0;
      settle();
      ext_scl_low = 1'b1;
      settle();
    end
  endtask

  task automatic take_buffer();
    rd(2'd1, got_buf);
    -> buf_ready;
    #1;
  endtask

  // Monitor: compare each produced buffer byte with the scoreboard (R6)
  initial begin
    forever begin
      @(buf_ready);
      if (exp_q.size() == 0) check("R6 unexpected buffer byte", got_buf, 8'hxx);
      else check("R6 buffer byte", got_buf, exp_q.pop_front());
    end
  end

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] tx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    rd(2'd0, v); check("R1 shift reg", v, 8'hFF);
    rd(2'd2, v); check("R1 status", v, 8'h00);
    rd(2'd3, v); check("R1 control", v, 8'h01);
    rd(2'd1, v); check("R1 buffer", v, 8'h00);
    check("R1 pins", {6'd0, scl_oe, sda_oe}, 8'h00);

    // R2 start, R3 hold
    ext_sda_low = 1'b1;
    settle();
    rd(2'd2, v); check("R2 start flag", v, 8'h80);
    check("R3 no hold while clock high", {7'd0, scl_oe}, 8'h00);
    ext_scl_low = 1'b1;
    settle();
    check("R3 hold after start", {7'd0, scl_oe}, 8'h01);
    wr(2'd2, 8'h80);
    settle();
    check("R3 release on clear", {7'd0, scl_oe}, 8'h00);
    rd(2'd2, v); check("R8 start cleared", v, 8'h00);

    // R4/R6 receive 0xA5
    ext_send_byte(8'hA5);
    rd(2'd2, v); check("R4 overflow after 16 edges", v, 8'h40);
    check("R4 hold on overflow", {7'd0, scl_oe}, 8'h01);
    take_buffer();

    // R5 single acknowledge bit via preload 1110, R10 drive
    ext_sda_low = 1'b0;
    wr(2'd3, 8'h02);
    wr(2'd0, 8'h00);
    check("R10 data pulled low", {7'd0, sda_oe}, 8'h01);
    wr(2'd2, 8'h4E);
    settle();
    rd(2'd2, v); check("R5 preload", v, 8'h0E);
    ext_scl_low = 1'b0;
    settle();
    rd(2'd2, v); check("R5 no overflow after rise", v, 8'h0F);
    ext_scl_low = 1'b1;
    settle();
    rd(2'd2, v); check("R5 overflow after one bit", v, 8'h40);
    rd(2'd1, v); check("R6 buffer after ack bit", v, 8'h00);

    // R7 stop
    wr(2'd3, 8'h00);
    check("R10 released when disabled", {7'd0, sda_oe}, 8'h00);
    ext_sda_low = 1'b1;
    wr(2'd2, 8'h40);
    settle();
    ext_scl_low = 1'b0;
    settle();
    ext_sda_low = 1'b0;
    settle();
    rd(2'd2, v); check("R7 stop flag", v, 8'h21);
    check("R7 no hold on stop", {7'd0, scl_oe}, 8'h00);

    // R8 zero writes keep flags, ones clear
    wr(2'd2, 8'h03);
    rd(2'd2, v); check("R8 flag kept on zero write", v, 8'h23);
    wr(2'd2, 8'h20);
    rd(2'd2, v); check("R8 flag cleared", v, 8'h00);

    // R9 toggle, R10 transmit 0xC3
    wr(2'd3, 8'h01);
    settle();
    rd(2'd3, v); check("R9 level low after toggle", v, 8'h00);
    check("R9 clock pulled", {7'd0, scl_oe}, 8'h01);
    wr(2'd2, 8'h00);
    tx = 8'hC3;
    wr(2'd0, tx);
    wr(2'd3, 8'h02);
    exp_q.push_back(tx);
    for (int i = 7; i >= 0; i--) begin
      check("R10 bit on data line", {7'd0, sda_oe}, {7'd0, ~tx[i]});
      wr(2'd3, 8'h03);
      settle();
      wr(2'd3, 8'h03);
      settle();
    end
    rd(2'd2, v); check("R11 no collision, R4 overflow", v, 8'h40);
    take_buffer();

    // R11 collision
    wr(2'd2, 8'h40);
    wr(2'd0, 8'hFF);
    ext_sda_low = 1'b1;
    settle();
    wr(2'd3, 8'h03);
    settle();
    rd(2'd2, v); check("R11 collision flag", v, 8'h11);
    wr(2'd3, 8'h03);
    settle();
    ext_sda_low = 1'b0;
    settle();

    check("R6 scoreboard drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule